// File: doc/BRIEF.md
# Ethernet MAC Command and Interrupt-Mask Register Slice

This block is the control-register slice of a simple Ethernet MAC. It sits on a byte-wide register bus and holds two registers. The one-byte command register starts a global soft reset and turns the transmit and receive engines on or off. The two-byte interrupt mask selects which per-source status bits may drive the single interrupt line.

The block sends a soft-reset strobe and the two enable requests to the transmit and receive engines. It takes back their activity flags, a completion flag for the soft reset, a receive-ring-empty flag and the raw interrupt status vector. Reads are combinational on the address. Writes take effect at the clock edge on which `reg_wr` is high. The bus has no handshake: every access completes in one cycle and is never stalled.

The soft reset clears itself. It ends after `SRST_CYCLES` cycles, or one cycle after the engines report completion if that comes first. The soft reset never touches the interrupt mask. Only the bus reset `rst_n` clears the mask and the enables.

Top module: `eth_ctl_regs`

## Requirements
- R1: After `rst_n` is released, `srst_o`, `tx_en_o`, `rx_en_o` and `irq_o` are 0, and the interrupt mask reads 0.
- R2: A write to address 0x37 with bit 4 set, made while no soft reset is running, raises `srst_o` on the next cycle. Bit 4 of address 0x37 then reads 1. If completion is not reported, `srst_o` stays high for exactly `SRST_CYCLES` cycles and then drops, and bit 4 reads 0 again.
- R3: While a soft reset runs, a high `srst_done_i` sampled at a clock edge ends the reset at that edge.
- R4: A write that starts a soft reset clears both enables, even if the same byte also sets bits 3 or 2. Writes to bits 3 and 2 while `srst_o` is high are ignored. The soft reset leaves the interrupt mask unchanged.
- R5: Outside a soft reset, a write to 0x37 with bit 4 clear sets `rx_en_o` to the written bit 3 on the next cycle.
- R6: Outside a soft reset, a write to 0x37 with bit 4 clear and bit 2 set sets `tx_en_o` only if `tx_busy_i` is low or `tx_en_o` is already 1. Writing bit 2 as 0 clears `tx_en_o`.
- R7: Bit 3 of address 0x37 reads `rx_active_i` and bit 2 reads `tx_busy_i`. These are the live engine states, not the values that were written.
- R8: Bit 0 of address 0x37 reads `rx_ring_empty_i`. Bits 7:5 and bit 1 read 0, and writing them has no effect. Unmapped addresses read 0x00.
- R9: Address 0x3C holds mask bits 7:0 and address 0x3D holds mask bits 15:8. Bit 15 enables the system-error source and bit 14 enables the timeout source. A 1 enables a source, and each byte reads back as written.
- R10: `irq_o` is the OR over all bits of (`irq_status_i` AND mask), registered. It changes one cycle after its inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset |
| reg_wr | input | 1 | Write strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| srst_o | output | 1 | Soft reset in progress, to the engines |
| tx_en_o | output | 1 | Transmit engine enable |
| rx_en_o | output | 1 | Receive engine enable |
| tx_busy_i | input | 1 | Transmit engine active |
| rx_active_i | input | 1 | Receive engine active |
| srst_done_i | input | 1 | Engines report soft reset complete |
| rx_ring_empty_i | input | 1 | No packets in the receive ring |
| irq_status_i | input | IRQ_W | Raw interrupt status bits |
| irq_o | output | 1 | Interrupt line |

## Verification
A start of the soft reset and an enable request can land in the same command write. The bench provokes this by writing 0x1C and requires that the reset wins: `srst_o` rises and both enables stay low. A second collision puts an enable write inside the reset window. It is judged by `rx_en_o` and `tx_en_o` staying low both during the window and after it closes. The bench also changes the interrupt mask while status is already present, and checks `irq_o` one cycle later.

// File: rtl/ecr_pkg.sv
package ecr_pkg;
  localparam int CMD_RST_BIT   = 4;
  localparam int CMD_RXE_BIT   = 3;
  localparam int CMD_TXE_BIT   = 2;
  localparam int CMD_EMPTY_BIT = 0;

  typedef struct packed {
    logic rst;
    logic rxe;
    logic txe;
  } cmd_req_t;

  function automatic cmd_req_t decode_cmd(input logic [7:0] d);
    cmd_req_t r;
    r.rst = d[CMD_RST_BIT];
    r.rxe = d[CMD_RXE_BIT];
    r.txe = d[CMD_TXE_BIT];
    return r;
  endfunction
endpackage

// File: rtl/ecr_srst_seq.sv
module ecr_srst_seq #(
  parameter int SRST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic done_i,
  output logic active_o
);
  localparam int CNT_W = (SRST_CYCLES > 1) ? $clog2(SRST_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SRST_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end
    end else if (done_i || cnt_q == LAST) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
endmodule

// File: rtl/ecr_cmd_ctl.sv
module ecr_cmd_ctl
  import ecr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  cmd_req_t req_i,
  input  logic     srst_active_i,
  input  logic     tx_busy_i,
  output logic     srst_start_o,
  output logic     tx_en_o,
  output logic     rx_en_o
);
  logic tx_en_q, rx_en_q;

  assign srst_start_o = wr_i & req_i.rst & ~srst_active_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else if (srst_start_o || srst_active_i) begin
      tx_en_q <= 1'b0;
      rx_en_q <= 1'b0;
    end else if (wr_i) begin
      rx_en_q <= req_i.rxe;
      tx_en_q <= req_i.txe & (tx_en_q | ~tx_busy_i);
    end
  end

  assign tx_en_o = tx_en_q;
  assign rx_en_o = rx_en_q;
endmodule

// File: rtl/ecr_irq_mask.sv
module ecr_irq_mask #(
  parameter int ADDR_W   = 8,
  parameter int IRQ_W    = 16,
  parameter int IMR_ADDR = 'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [IRQ_W-1:0]  status_i,
  output logic [IRQ_W-1:0]  mask_o,
  output logic              irq_o
);
  localparam int NBYTES = IRQ_W / 8;

  logic [IRQ_W-1:0] mask_q;
  logic             irq_q;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic [ADDR_W-1:0] BADDR = ADDR_W'(IMR_ADDR + b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q[b*8 +: 8] <= '0;
      else if (wr_i && addr_i == BADDR) mask_q[b*8 +: 8] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_i & mask_q);
  end

  assign mask_o = mask_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/eth_ctl_regs.sv
module eth_ctl_regs
  import ecr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int IRQ_W       = 16,
  parameter int SRST_CYCLES = 8,
  parameter int CMD_ADDR    = 'h37,
  parameter int IMR_ADDR    = 'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              srst_o,
  output logic              tx_en_o,
  output logic              rx_en_o,
  input  logic              tx_busy_i,
  input  logic              rx_active_i,
  input  logic              srst_done_i,
  input  logic              rx_ring_empty_i,
  input  logic [IRQ_W-1:0]  irq_status_i,
  output logic              irq_o
);
  localparam int NBYTES = IRQ_W / 8;
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);

  logic             cmd_wr;
  logic             srst_start;
  logic             srst_active;
  logic [IRQ_W-1:0] imr_q;

  assign cmd_wr = reg_wr && reg_addr == CMD_A;

  ecr_srst_seq #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (srst_start),
    .done_i   (srst_done_i),
    .active_o (srst_active)
  );

  ecr_cmd_ctl u_cmd (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_i          (cmd_wr),
    .req_i         (decode_cmd(reg_wdata)),
    .srst_active_i (srst_active),
    .tx_busy_i     (tx_busy_i),
    .srst_start_o  (srst_start),
    .tx_en_o       (tx_en_o),
    .rx_en_o       (rx_en_o)
  );

  ecr_irq_mask #(.ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .IMR_ADDR(IMR_ADDR)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .status_i (irq_status_i),
    .mask_o   (imr_q),
    .irq_o    (irq_o)
  );

  assign srst_o = srst_active;

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CMD_A) begin
      reg_rdata[CMD_RST_BIT]   = srst_active;
      reg_rdata[CMD_RXE_BIT]   = rx_active_i;
      reg_rdata[CMD_TXE_BIT]   = tx_busy_i;
      reg_rdata[CMD_EMPTY_BIT] = rx_ring_empty_i;
    end
    for (int b = 0; b < NBYTES; b++) begin
      if (reg_addr == ADDR_W'(IMR_ADDR + b)) reg_rdata = imr_q[b*8 +: 8];
    end
  end
endmodule

// File: rtl/eth_ctl_regs_chk.sv
module eth_ctl_regs_chk #(
  parameter int ADDR_W      = 8,
  parameter int IRQ_W       = 16,
  parameter int SRST_CYCLES = 8,
  parameter int CMD_ADDR    = 'h37
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              w_rst,
  input logic              w_rxe,
  input logic              w_txe,
  input logic              srst_o,
  input logic              tx_en_o,
  input logic              rx_en_o,
  input logic [IRQ_W-1:0]  status,
  input logic [IRQ_W-1:0]  mask,
  input logic              irq_o
);
  logic cmd_wr;
  int   act_cnt;

  assign cmd_wr = reg_wr && reg_addr == ADDR_W'(CMD_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act_cnt <= 0;
    else if (srst_o) act_cnt <= act_cnt + 1;
    else             act_cnt <= 0;
  end

  // R2
  srst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && w_rst && !srst_o |=> srst_o);

  // R2
  srst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |-> act_cnt < SRST_CYCLES);

  // R4
  srst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_o |-> !tx_en_o && !rx_en_o);

  // R5
  rx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !w_rst && !srst_o |=> rx_en_o == $past(w_rxe));

  // R6
  tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !w_txe |=> !tx_en_o);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status & mask) == '0 |=> !irq_o);
endmodule

bind eth_ctl_regs eth_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .IRQ_W(IRQ_W), .SRST_CYCLES(SRST_CYCLES), .CMD_ADDR(CMD_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .w_rst    (reg_wdata[4]),
  .w_rxe    (reg_wdata[3]),
  .w_txe    (reg_wdata[2]),
  .srst_o   (srst_o),
  .tx_en_o  (tx_en_o),
  .rx_en_o  (rx_en_o),
  .status   (irq_status_i),
  .mask     (imr_q),
  .irq_o    (irq_o)
);

// File: tb/eth_ctl_regs_test.sv
`timescale 1ns/1ps
module eth_ctl_regs_test;
  localparam int NCYC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        srst_o, tx_en_o, rx_en_o, irq_o;
  logic        tx_busy, rx_active;
  logic        tx_drain = 1'b0;
  logic        srst_done = 1'b0;
  logic        ring_empty = 1'b1;
  logic [15:0] status = '0;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  eth_ctl_regs #(.SRST_CYCLES(NCYC)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .srst_o(srst_o),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .tx_busy_i(tx_busy),
    .rx_active_i(rx_active), .srst_done_i(srst_done),
    .rx_ring_empty_i(ring_empty), .irq_status_i(status), .irq_o(irq_o)
  );

  // behavioural engine stubs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_busy   <= 1'b0;
      rx_active <= 1'b0;
    end else begin
      tx_busy   <= tx_en_o | tx_drain;
      rx_active <= rx_en_o;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h37, d); chk("R1 cmd after reset", d, 8'h01);
    rd(8'h3C, d); chk("R1 mask low", d, 0);
    rd(8'h3D, d); chk("R1 mask high", d, 0);
    chk("R1 srst_o", srst_o, 0);
    chk("R1 enables", {tx_en_o, rx_en_o}, 0);
    chk("R1 irq_o", irq_o, 0);
  endtask

  task automatic t_rx();
    logic [7:0] d;
    wr(8'h37, 8'h08);
    chk("R5 rx_en_o set", rx_en_o, 1);
    rd(8'h37, d); chk("R7 rx bit before engine active", d[3], 0);
    @(negedge clk);
    rd(8'h37, d); chk("R7 rx bit live", d[3], 1);
    wr(8'h37, 8'h00);
    chk("R5 rx_en_o cleared", rx_en_o, 0);
  endtask

  task automatic t_tx();
    logic [7:0] d;
    tx_drain = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h37, 8'h04);
    chk("R6 tx enable ignored while busy", tx_en_o, 0);
    rd(8'h37, d); chk("R7 tx bit reads busy not written", d[2], 1);
    tx_drain = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h37, 8'h04);
    chk("R6 tx enable when idle", tx_en_o, 1);
    tx_drain = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h37, 8'h04);
    chk("R6 tx stays enabled while active", tx_en_o, 1);
    wr(8'h37, 8'h00);
    chk("R6 tx disable", tx_en_o, 0);
    tx_drain = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    ring_empty = 1'b0;
    wr(8'h37, 8'hE3);
    chk("R8 reserved write no enable", {srst_o, tx_en_o, rx_en_o}, 0);
    rd(8'h37, d); chk("R8 reserved bits read 0, empty=0", d, 8'h00);
    ring_empty = 1'b1;
    rd(8'h37, d); chk("R8 empty bit", d, 8'h01);
    wr(8'h40, 8'hFF);
    rd(8'h40, d); chk("R8 unmapped reads 0", d, 0);
    chk("R8 unmapped write no effect", {srst_o, tx_en_o, rx_en_o}, 0);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(8'h3C, 8'hA5);
    wr(8'h3D, 8'hC0);
    rd(8'h3C, d); chk("R9 mask low readback", d, 8'hA5);
    rd(8'h3D, d); chk("R9 mask high readback", d, 8'hC0);
  endtask

  task automatic t_srst_full();
    logic [7:0] d;
    int cnt;
    wr(8'h37, 8'h0C);
    @(negedge clk);
    wr(8'h37, 8'h10);
    chk("R2 srst_o rises", srst_o, 1);
    chk("R4 enables cleared by reset", {tx_en_o, rx_en_o}, 0);
    rd(8'h37, d); chk("R2 reset bit reads 1", d[4], 1);
    cnt = 0;
    while (srst_o && cnt < 50) begin
      cnt++;
      @(negedge clk);
    end
    chk("R2 reset length", cnt, NCYC);
    rd(8'h37, d); chk("R2 reset bit self-clears", d[4], 0);
    rd(8'h3D, d); chk("R4 mask kept over soft reset", d, 8'hC0);
  endtask

  task automatic t_srst_ignore();
    wr(8'h37, 8'h10);
    wr(8'h37, 8'h0C);
    chk("R4 enable write ignored in window", {tx_en_o, rx_en_o}, 0);
    while (srst_o) @(negedge clk);
    @(negedge clk);
    chk("R4 enables still off after window", {tx_en_o, rx_en_o}, 0);
  endtask

  task automatic t_srst_early();
    wr(8'h37, 8'h10);
    @(negedge clk);
    chk("R3 still in reset", srst_o, 1);
    srst_done = 1'b1;
    @(negedge clk);
    srst_done = 1'b0;
    chk("R3 early completion", srst_o, 0);
  endtask

  task automatic t_collide();
    wr(8'h37, 8'h1C);
    chk("R4 reset wins over enables: srst", srst_o, 1);
    chk("R4 reset wins over enables: en", {tx_en_o, rx_en_o}, 0);
    while (srst_o) @(negedge clk);
  endtask

  task automatic t_irq();
    @(negedge clk);
    status = 16'h4000;
    #0.5; chk("R10 irq registered, not yet", irq_o, 0);
    @(negedge clk);
    chk("R10 timeout source raises irq", irq_o, 1);
    status = 16'h0002;
    @(negedge clk);
    chk("R10 masked-off source no irq", irq_o, 0);
    status = 16'h0100;
    @(negedge clk);
    chk("R10 bit8 disabled", irq_o, 0);
    wr(8'h3D, 8'h01);
    @(negedge clk);
    chk("R9 R10 mask write enables bit8", irq_o, 1);
    wr(8'h3D, 8'h00);
    @(negedge clk);
    chk("R10 mask cleared drops irq", irq_o, 0);
    status = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx();
    t_tx();
    t_reserved();
    t_mask();
    t_srst_full();
    t_srst_ignore();
    t_srst_early();
    t_collide();
    t_irq();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule